// File: doc/BRIEF.md
# Double-Precision to Signed Integer Converter

This unit turns one IEEE-754 binary64 operand into a signed two's-complement integer, either 32 or 64 bits wide. The result appears one clock after the request and carries a write strobe for the destination register, plus two exception flags: invalid and inexact. The operand is the low 64 bits of whatever source feeds the unit, so a vector-register lane or a memory word looks the same here.

Rounding normally follows a 2-bit field from a global control register. An operation may carry its own 2-bit rounding field. That field wins only when its enable bit is set and the operand was read from a register. Values that do not fit the chosen width, and all NaNs and infinities, are invalid. With the invalid exception masked, the unit writes the indefinite value, which is the sign bit alone. With it unmasked, the destination write is suppressed. The 64-bit width takes effect only while the core runs in 64-bit mode. Otherwise the request falls back to 32 bits.

Top module: `dbl2int_unit`

## Requirements
- R1: Every request with `in_valid` high produces `out_valid` high exactly one clock later. A cycle with `in_valid` low yields `out_valid`, `wr_en`, both flags and `result` all zero one clock later, and all outputs are zero during reset.
- R2: The effective rounding code selects the mode as follows:
  - 00: nearest, ties to even.
  - 01: toward negative infinity.
  - 10: toward positive infinity.
  - 11: toward zero.
- R3: The per-operation field `op_rm` is used only when `op_rm_en` and `src_is_reg` are both 1. Otherwise `ctrl_rm` is used.
- R4: At 32-bit width, a rounded value outside [-2^31, 2^31-1] is invalid, including a value pushed out of range by rounding. When masked, the result is 0x0000_0000_8000_0000.
- R5: At 64-bit width, a rounded value outside [-2^63, 2^63-1] is invalid. When masked, the result is 0x8000_0000_0000_0000.
- R6: The width is 64 bits only when `size64` and `mode64` are both 1, and 32 bits otherwise. A 32-bit result occupies `result[31:0]`, and `result[63:32]` is zero.
- R7: An exponent field of all ones (infinity, quiet or signalling NaN) always raises `flag_invalid`, whatever the sign or width.
- R8: `flag_inexact` is 1 exactly when an in-range conversion discards nonzero fraction bits. It is never 1 together with `flag_invalid`.
- R9: An invalid conversion with `inv_masked` at 0 gives `flag_invalid` 1, `wr_en` 0 and `result` 0. A valid conversion gives `wr_en` 1 regardless of `inv_masked`.
- R10: Zeros convert to 0 without inexact. Denormals convert to 0, or to ±1 under directed rounding away from zero, with inexact. A negative value that rounds to zero returns all-zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Conversion request |
| src | input | 64 | Binary64 operand |
| size64 | input | 1 | Requests a 64-bit destination |
| mode64 | input | 1 | Core is in 64-bit mode |
| ctrl_rm | input | 2 | Global rounding control field |
| op_rm | input | 2 | Per-operation rounding field |
| op_rm_en | input | 1 | Enables the per-operation rounding field |
| src_is_reg | input | 1 | Operand was read from a register |
| inv_masked | input | 1 | Invalid exception is masked |
| out_valid | output | 1 | Result cycle of a request |
| wr_en | output | 1 | Destination write strobe |
| result | output | 64 | Integer result |
| flag_invalid | output | 1 | Invalid flag |
| flag_inexact | output | 1 | Inexact (precision) flag |

## Verification
The increment chosen by rounding and the range check act in the same cycle. A carry out of the increment can turn an in-range magnitude into an overflow, and that overflow must then mask the inexact flag. The bench provokes this with 2147483647.5 at 32-bit width. Under ties-to-even it rounds up to 2^31 and must come back invalid with the indefinite value and no inexact flag. Under round-toward-zero the same operand must return 0x7FFFFFFF with inexact set.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;
    localparam int FP_W     = 64;
    localparam int EXP_W    = 11;
    localparam int MAN_W    = 52;
    localparam int BIAS     = 1023;
    localparam int INT_W    = 64;
    localparam int NARROW_W = 32;
    localparam int SIG_W    = MAN_W + 1;
    localparam int MAG_W    = INT_W + 1;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [INT_W-1:0] res;
        logic             inv;
        logic             inx;
    } out_t;
endpackage

// File: rtl/dbl2int_rmode_sel.sv
module dbl2int_rmode_sel
    import dbl2int_pkg::*;
(
    input  logic [1:0] ctrl_rm,
    input  logic [1:0] op_rm,
    input  logic       op_rm_en,
    input  logic       src_reg,
    output rmode_e     rm
);
    logic use_op;

    always_comb begin
        use_op = op_rm_en && src_reg;
        rm     = rmode_e'(use_op ? op_rm : ctrl_rm);
    end
endmodule

// File: rtl/dbl2int_align.sv
module dbl2int_align
    import dbl2int_pkg::*;
(
    input  logic [FP_W-1:0]  opnd,
    output logic             sgn,
    output logic             special,
    output logic             huge,
    output logic [MAG_W-1:0] mag,
    output logic             rnd,
    output logic             stk
);
    localparam int EXT_W = SIG_W + INT_W;
    localparam int SE_W  = EXP_W + 2;
    localparam logic signed [SE_W-1:0] BIAS_S  = SE_W'(BIAS);
    localparam logic signed [SE_W-1:0] MAN_S   = SE_W'(MAN_W);
    localparam logic signed [SE_W-1:0] TOP_S   = SE_W'(INT_W - 1);
    localparam logic signed [SE_W-1:0] SHMAX_S = SE_W'(INT_W);
    localparam logic signed [SE_W-1:0] ZERO_S  = '0;

    logic [EXP_W-1:0]        ex;
    logic [SIG_W-1:0]        sig;
    logic signed [SE_W-1:0]  unb;
    logic signed [SE_W-1:0]  sh;
    logic [SE_W-1:0]         lsh;
    logic [EXT_W-1:0]        ext;

    always_comb begin
        sgn     = opnd[FP_W-1];
        ex      = opnd[FP_W-2 -: EXP_W];
        sig     = {|ex, opnd[MAN_W-1:0]};
        special = &ex;
        unb     = $signed({2'b00, ex}) - BIAS_S;
        sh      = MAN_S - unb;
        lsh     = SE_W'(ZERO_S - sh);
        huge    = !special && (unb > TOP_S);
        mag     = '0;
        rnd     = 1'b0;
        stk     = 1'b0;
        ext     = '0;
        if (special || huge) begin
            mag = '0;
        end else if (sh <= ZERO_S) begin
            // integer already, shift left into place
            mag = MAG_W'(sig) << lsh;
        end else if (sh <= SHMAX_S) begin
            // split into integer part, round bit and sticky bits
            ext = {sig, {INT_W{1'b0}}} >> sh;
            mag = MAG_W'(ext[EXT_W-1:INT_W]);
            rnd = ext[INT_W-1];
            stk = |ext[INT_W-2:0];
        end else begin
            stk = |sig;
        end
    end
endmodule

// File: rtl/dbl2int_round_pack.sv
module dbl2int_round_pack
    import dbl2int_pkg::*;
(
    input  rmode_e           rm,
    input  logic             wide,
    input  logic             sgn,
    input  logic             special,
    input  logic             huge,
    input  logic [MAG_W-1:0] mag,
    input  logic             rnd,
    input  logic             stk,
    output logic             invalid,
    output logic             inexact,
    output logic [INT_W-1:0] value
);
    localparam logic [MAG_W-1:0] POS_W   = (MAG_W'(1) << (INT_W - 1)) - MAG_W'(1);
    localparam logic [MAG_W-1:0] NEG_W   = MAG_W'(1) << (INT_W - 1);
    localparam logic [MAG_W-1:0] POS_N   = (MAG_W'(1) << (NARROW_W - 1)) - MAG_W'(1);
    localparam logic [MAG_W-1:0] NEG_N   = MAG_W'(1) << (NARROW_W - 1);
    localparam logic [INT_W-1:0] INDEF_W = INT_W'(1) << (INT_W - 1);
    localparam logic [INT_W-1:0] INDEF_N = INT_W'(1) << (NARROW_W - 1);

    logic             frac;
    logic             inc;
    logic             in_range;
    logic [MAG_W-1:0] rmag;
    logic [MAG_W-1:0] lim;
    logic [INT_W-1:0] twos;
    logic [INT_W-1:0] narrow_ext;

    always_comb begin
        frac = rnd | stk;
        inc  = 1'b0;
        unique case (rm)
            RM_NEAR: inc = rnd & (stk | mag[0]);
            RM_DOWN: inc = sgn & frac;
            RM_UP:   inc = !sgn & frac;
            RM_ZERO: inc = 1'b0;
        endcase
        rmag     = mag + MAG_W'(inc);
        lim      = wide ? (sgn ? NEG_W : POS_W) : (sgn ? NEG_N : POS_N);
        in_range = !special && !huge && (rmag <= lim);
        invalid  = !in_range;
        inexact  = in_range && frac;
        twos     = sgn ? (~rmag[INT_W-1:0] + INT_W'(1)) : rmag[INT_W-1:0];
    end

    generate
        if (INT_W > NARROW_W) begin : g_zext
            assign narrow_ext = {{(INT_W - NARROW_W){1'b0}}, twos[NARROW_W-1:0]};
        end else begin : g_same
            assign narrow_ext = twos;
        end
    endgenerate

    always_comb begin
        if (wide) value = invalid ? INDEF_W : twos;
        else      value = invalid ? INDEF_N : narrow_ext;
    end
endmodule

// File: rtl/dbl2int_unit.sv
module dbl2int_unit
    import dbl2int_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  src,
    input  logic             size64,
    input  logic             mode64,
    input  logic [1:0]       ctrl_rm,
    input  logic [1:0]       op_rm,
    input  logic             op_rm_en,
    input  logic             src_is_reg,
    input  logic             inv_masked,
    output logic             out_valid,
    output logic             wr_en,
    output logic [INT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact
);
    localparam logic [INT_W-1:0] IND64 = INT_W'(1) << (INT_W - 1);
    localparam logic [INT_W-1:0] IND32 = INT_W'(1) << (NARROW_W - 1);

    rmode_e           rm;
    logic             wide;
    logic             sgn, special, huge, rnd, stk;
    logic [MAG_W-1:0] mag;
    logic             invalid, inexact;
    logic [INT_W-1:0] value;
    out_t             st_d, st_q;

    assign wide = size64 && mode64;

    dbl2int_rmode_sel u_rsel (
        .ctrl_rm  (ctrl_rm),
        .op_rm    (op_rm),
        .op_rm_en (op_rm_en),
        .src_reg  (src_is_reg),
        .rm       (rm)
    );

    dbl2int_align u_align (
        .opnd    (src),
        .sgn     (sgn),
        .special (special),
        .huge    (huge),
        .mag     (mag),
        .rnd     (rnd),
        .stk     (stk)
    );

    dbl2int_round_pack u_rpack (
        .rm      (rm),
        .wide    (wide),
        .sgn     (sgn),
        .special (special),
        .huge    (huge),
        .mag     (mag),
        .rnd     (rnd),
        .stk     (stk),
        .invalid (invalid),
        .inexact (inexact),
        .value   (value)
    );

    always_comb begin
        st_d     = '0;
        st_d.vld = in_valid;
        st_d.inv = in_valid && invalid;
        st_d.inx = in_valid && inexact;
        st_d.wr  = in_valid && (!invalid || inv_masked);
        st_d.res = st_d.wr ? value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.vld;
    assign wr_en        = st_q.wr;
    assign result       = st_q.res;
    assign flag_invalid = st_q.inv;
    assign flag_inexact = st_q.inx;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !flag_invalid && !flag_inexact));
    p_indef32_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_masked && !wide) |=> (!flag_invalid || result == IND32));
    p_indef64_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inv_masked && wide) |=> (!flag_invalid || result == IND64));
    p_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[INT_W-1:NARROW_W] == '0));
    p_special_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && special) |=> flag_invalid);
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> !flag_inexact);
    p_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inv_masked) |=> !(flag_invalid && wr_en));
endmodule

// File: tb/dbl2int_unit_bench.sv
module dbl2int_unit_bench;
    typedef struct {
        logic [63:0] res;
        logic        inv;
        logic        inx;
        logic        wr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic        size64 = 1'b0, mode64 = 1'b0;
    logic [1:0]  ctrl_rm = 2'b00, op_rm = 2'b00;
    logic        op_rm_en = 1'b0, src_is_reg = 1'b1, inv_masked = 1'b1;
    logic        out_valid, wr_en, flag_invalid, flag_inexact;
    logic [63:0] result;

    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    dbl2int_unit u_dbl2int_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .size64(size64), .mode64(mode64), .ctrl_rm(ctrl_rm), .op_rm(op_rm),
        .op_rm_en(op_rm_en), .src_is_reg(src_is_reg), .inv_masked(inv_masked),
        .out_valid(out_valid), .wr_en(wr_en), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    localparam logic [63:0] I32 = 64'h0000_0000_8000_0000;
    localparam logic [63:0] I64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_1    = 64'h3FF0000000000000;
    localparam logic [63:0] D_M1   = 64'hBFF0000000000000;
    localparam logic [63:0] D_2P5  = 64'h4004000000000000;
    localparam logic [63:0] D_M2P5 = 64'hC004000000000000;
    localparam logic [63:0] D_3P5  = 64'h400C000000000000;
    localparam logic [63:0] D_1P5  = 64'h3FF8000000000000;
    localparam logic [63:0] D_HALF = 64'h3FE0000000000000;
    localparam logic [63:0] D_MHALF= 64'hBFE0000000000000;
    localparam logic [63:0] D_2P31 = 64'h41E0000000000000;
    localparam logic [63:0] D_M2P31= 64'hC1E0000000000000;
    localparam logic [63:0] D_MAX32= 64'h41DFFFFFFFC00000;
    localparam logic [63:0] D_TIE32= 64'h41DFFFFFFFE00000;
    localparam logic [63:0] D_2P63 = 64'h43E0000000000000;
    localparam logic [63:0] D_M2P63= 64'hC3E0000000000000;
    localparam logic [63:0] D_BIG63= 64'h43DFFFFFFFFFFFFF;
    localparam logic [63:0] D_2P40 = 64'h4270000000000000;
    localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
    localparam logic [63:0] D_NINF = 64'hFFF0000000000000;
    localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] D_SNAN = 64'h7FF0000000000001;
    localparam logic [63:0] D_PZ   = 64'h0000000000000000;
    localparam logic [63:0] D_NZ   = 64'h8000000000000000;
    localparam logic [63:0] D_DEN  = 64'h0000000000000001;
    localparam logic [63:0] D_NDEN = 64'h8000000000000001;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // w: {size64,mode64}; rm: {ctrl_rm}; o: {op_rm_en,src_is_reg,op_rm}; m: inv_masked
    task automatic go(input logic [63:0] op, input logic [1:0] w, input logic [1:0] crm,
                      input logic [3:0] o, input logic m,
                      input logic [63:0] e_res, input logic e_inv, input logic e_inx,
                      input logic e_wr, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        src        = op;
        size64     = w[1];
        mode64     = w[0];
        ctrl_rm    = crm;
        op_rm_en   = o[3];
        src_is_reg = o[2];
        op_rm      = o[1:0];
        inv_masked = m;
        e.res = e_res; e.inv = e_inv; e.inx = e_inx; e.wr = e_wr; e.tag = tag;
        sb.push_back(e);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R1 unexpected out_valid", {63'b0, out_valid}, 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(result == e.res && flag_invalid == e.inv && flag_inexact == e.inx && wr_en == e.wr,
                    e.tag, {result[63:3], flag_invalid, flag_inexact, wr_en} ^ 64'h0 | 64'h0,
                    {e.res[63:3], e.inv, e.inx, e.wr});
                if (result != e.res)
                    $display("  detail %s: result %h expected %h", e.tag, result, e.res);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !wr_en && result == 64'h0 && !flag_invalid && !flag_inexact,
            "R1 reset state", result, 64'h0);
        rst_n = 1'b1;

        // R2 rounding modes
        go(D_1,    2'b00, 2'b00, 4'b0100, 1, 64'h1, 0, 0, 1, "R2 1.0 nearest");
        go(D_2P5,  2'b00, 2'b00, 4'b0100, 1, 64'h2, 0, 1, 1, "R2 2.5 nearest tie even");
        go(D_3P5,  2'b00, 2'b00, 4'b0100, 1, 64'h4, 0, 1, 1, "R2 3.5 nearest tie up");
        go(D_2P5,  2'b00, 2'b01, 4'b0100, 1, 64'h2, 0, 1, 1, "R2 2.5 down");
        go(D_2P5,  2'b00, 2'b10, 4'b0100, 1, 64'h3, 0, 1, 1, "R2 2.5 up");
        go(D_2P5,  2'b00, 2'b11, 4'b0100, 1, 64'h2, 0, 1, 1, "R2 2.5 zero");
        go(D_M2P5, 2'b00, 2'b00, 4'b0100, 1, 64'h0000_0000_FFFF_FFFE, 0, 1, 1, "R2 -2.5 nearest");
        go(D_M2P5, 2'b00, 2'b01, 4'b0100, 1, 64'h0000_0000_FFFF_FFFD, 0, 1, 1, "R2 -2.5 down");
        go(D_M2P5, 2'b00, 2'b10, 4'b0100, 1, 64'h0000_0000_FFFF_FFFE, 0, 1, 1, "R2 -2.5 up");
        go(D_M2P5, 2'b00, 2'b11, 4'b0100, 1, 64'h0000_0000_FFFF_FFFE, 0, 1, 1, "R2 -2.5 zero");
        go(D_1P5,  2'b00, 2'b11, 4'b0100, 1, 64'h1, 0, 1, 1, "R2 1.5 zero");

        // R3 override selection
        go(D_2P5, 2'b00, 2'b00, 4'b1110, 1, 64'h3, 0, 1, 1, "R3 override used");
        go(D_2P5, 2'b00, 2'b00, 4'b1010, 1, 64'h2, 0, 1, 1, "R3 override ignored memory source");
        go(D_2P5, 2'b00, 2'b00, 4'b0110, 1, 64'h2, 0, 1, 1, "R3 override ignored when disabled");
        go(D_2P5, 2'b00, 2'b10, 4'b1111, 1, 64'h2, 0, 1, 1, "R3 override toward zero beats ctrl up");

        // R4 32-bit range
        go(D_MAX32, 2'b00, 2'b00, 4'b0100, 1, 64'h7FFF_FFFF, 0, 0, 1, "R4 max int32");
        go(D_2P31,  2'b00, 2'b00, 4'b0100, 1, I32, 1, 0, 1, "R4 2^31 overflow");
        go(D_M2P31, 2'b00, 2'b00, 4'b0100, 1, I32, 0, 0, 1, "R4 -2^31 fits");
        go(D_TIE32, 2'b00, 2'b00, 4'b0100, 1, I32, 1, 0, 1, "R4 R8 rounding carry overflow");
        go(D_TIE32, 2'b00, 2'b11, 4'b0100, 1, 64'h7FFF_FFFF, 0, 1, 1, "R4 R8 toward zero stays in range");

        // R5 64-bit range
        go(D_2P31,  2'b11, 2'b00, 4'b0100, 1, 64'h0000_0000_8000_0000, 0, 0, 1, "R5 2^31 wide");
        go(D_BIG63, 2'b11, 2'b00, 4'b0100, 1, 64'h7FFF_FFFF_FFFF_FC00, 0, 0, 1, "R5 largest below 2^63");
        go(D_2P63,  2'b11, 2'b00, 4'b0100, 1, I64, 1, 0, 1, "R5 2^63 overflow");
        go(D_M2P63, 2'b11, 2'b00, 4'b0100, 1, I64, 0, 0, 1, "R5 -2^63 fits");
        go(D_M1,    2'b11, 2'b00, 4'b0100, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, "R5 -1 wide");

        // R6 width selection
        go(D_2P40, 2'b11, 2'b00, 4'b0100, 1, 64'h0000_0100_0000_0000, 0, 0, 1, "R6 2^40 wide");
        go(D_2P40, 2'b10, 2'b00, 4'b0100, 1, I32, 1, 0, 1, "R6 size64 without mode64");
        go(D_2P40, 2'b01, 2'b00, 4'b0100, 1, I32, 1, 0, 1, "R6 mode64 without size64");
        go(D_M1,   2'b00, 2'b00, 4'b0100, 1, 64'h0000_0000_FFFF_FFFF, 0, 0, 1, "R6 -1 narrow zero upper");

        // R7 specials
        go(D_PINF, 2'b00, 2'b00, 4'b0100, 1, I32, 1, 0, 1, "R7 +inf narrow");
        go(D_NINF, 2'b11, 2'b11, 4'b0100, 1, I64, 1, 0, 1, "R7 -inf wide");
        go(D_QNAN, 2'b11, 2'b00, 4'b0100, 1, I64, 1, 0, 1, "R7 qnan wide");
        go(D_SNAN, 2'b00, 2'b10, 4'b0100, 1, I32, 1, 0, 1, "R7 snan narrow");

        // R9 unmasked invalid
        go(D_2P31, 2'b00, 2'b00, 4'b0100, 0, 64'h0, 1, 0, 0, "R9 unmasked overflow");
        go(D_QNAN, 2'b11, 2'b00, 4'b0100, 0, 64'h0, 1, 0, 0, "R9 unmasked nan");
        go(D_1,    2'b00, 2'b00, 4'b0100, 0, 64'h1, 0, 0, 1, "R9 unmasked valid writes");

        // R10 zeros and denormals
        go(D_PZ,    2'b00, 2'b00, 4'b0100, 1, 64'h0, 0, 0, 1, "R10 +0");
        go(D_NZ,    2'b11, 2'b01, 4'b0100, 1, 64'h0, 0, 0, 1, "R10 -0");
        go(D_DEN,   2'b00, 2'b00, 4'b0100, 1, 64'h0, 0, 1, 1, "R10 denorm nearest");
        go(D_DEN,   2'b00, 2'b10, 4'b0100, 1, 64'h1, 0, 1, 1, "R10 denorm up");
        go(D_NDEN,  2'b00, 2'b01, 4'b0100, 1, 64'h0000_0000_FFFF_FFFF, 0, 1, 1, "R10 neg denorm down");
        go(D_NDEN,  2'b11, 2'b10, 4'b0100, 1, 64'h0, 0, 1, 1, "R10 neg denorm up no sign");
        go(D_HALF,  2'b00, 2'b00, 4'b0100, 1, 64'h0, 0, 1, 1, "R10 0.5 nearest");
        go(D_MHALF, 2'b11, 2'b00, 4'b0100, 1, 64'h0, 0, 1, 1, "R10 -0.5 nearest no sign");
        go(D_HALF,  2'b00, 2'b10, 4'b0100, 1, 64'h1, 0, 1, 1, "R10 0.5 up");

        @(negedge clk);
        in_valid = 1'b0;
        src = D_QNAN;
        repeat (2) @(negedge clk);
        chk(!out_valid && !wr_en && result == 64'h0 && !flag_invalid && !flag_inexact,
            "R1 idle after gap", result, 64'h0);
        chk(sb.size() == 0, "R1 all results returned", 64'(sb.size()), 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule